// File: doc/BRIEF.md
# Table-Driven Serial Field Splitter

This block watches one serial data line that is sampled once per clock and splits the bit stream into a fixed sequence of fields. A parameter table gives the bit length of each field, indexed by field number. No case branch encodes a particular frame layout, so the same hardware can decode any protocol whose fields always arrive in the same order. Several copies can sit side by side, each with its own table.

Capture runs while `start` is high. The block visits the fields strictly in ascending order and takes one bit per clock. When a field's last bit arrives, it reports the field number and the field value twice: once with the first received bit as the most significant bit, and once with the first received bit as bit 0. A one-cycle strobe marks each result. A second strobe marks the end of the last field. The block then wraps to field 0 if `start` is still high. Dropping `start` discards any partial field.

Top module: `field_splitter`

## Requirements
- R1: After synchronous reset, `field_valid` and `frame_done` are 0, and `field_idx`, `field_msb` and `field_lsb` are 0.
- R2: At any clock edge where `start` is 0, no bit is taken and any partly collected field is discarded. The next edge with `start` at 1 takes the first bit of field 0, and `field_valid` is 0 in the cycle after an edge with `start` at 0.
- R3: Each edge with `start` at 1 samples exactly one bit of `sdata`. Field k takes as many edges as its table length. `field_valid` is 1 for exactly the one cycle that follows the edge that took the field's last bit.
- R4: Fields are visited in the order 0, 1, …, NUM_FIELDS-1 with no branching on data. `field_idx` carries the number of the field being reported.
- R5: `field_msb` holds the field right-aligned, with the first received bit at position length-1 and the last received bit at bit 0.
- R6: `field_lsb` holds the same bits reversed: the first received bit at bit 0 and the last at position length-1.
- R7: In both outputs, every bit at or above the field length is 0.
- R8: `frame_done` pulses together with `field_valid` of field NUM_FIELDS-1. If `start` stays at 1, the following edge takes the first bit of field 0.
- R9: A table entry of 0 is treated as a length of 1.
- R10: Lengths from 1 up to 64 bits are supported. The length of field k is entry k of `LEN_TABLE`, 7 bits wide, at bit position 7k.
- R11: Instances with different tables work independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture enable; low discards and restarts |
| sdata | input | 1 | Serial data bit |
| field_valid | output | 1 | One-cycle strobe for a completed field |
| frame_done | output | 1 | Strobe with the last field of a frame |
| field_idx | output | IDX_W | Number of the completed field |
| field_msb | output | 64 | Field value, first bit most significant |
| field_lsb | output | 64 | Field value, first bit least significant |

## Verification
The bench builds two copies that share the same inputs. The first uses the default table (1, 64, 0, 8). That table reaches the 1-bit and 64-bit extremes and a zero entry that must act as one bit. The second uses seven 8-bit fields, which checks that the number of fields and the table apply per instance. Random frames with random drops of `start` exercise discards mid-field, and continuous runs exercise wrapping from the last field back to field 0.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
    localparam int LEN_W  = 7;
    localparam int DATA_W = 64;

    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        word_t msb;
        word_t lsb;
    } field_val_t;

    function automatic len_t eff_len(input len_t raw);
        return (raw == '0) ? len_t'(1) : raw;
    endfunction
endpackage

// File: rtl/sfd_len_rom.sv
module sfd_len_rom
    import sfd_pkg::*;
#(
    parameter int NUM_FIELDS = 4,
    parameter int IDX_W      = 2,
    parameter logic [NUM_FIELDS*LEN_W-1:0] LEN_TABLE = '0
) (
    input  logic [IDX_W-1:0] idx,
    output len_t             len
);
    len_t lens [NUM_FIELDS];

    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_ent
        assign lens[k] = eff_len(LEN_TABLE[k*LEN_W +: LEN_W]);
    end

    always_comb begin
        len = len_t'(1);
        for (int k = 0; k < NUM_FIELDS; k++)
            if (idx == IDX_W'(k)) len = lens[k];
    end
endmodule

// File: rtl/sfd_seq.sv
module sfd_seq
    import sfd_pkg::*;
#(
    parameter int NUM_FIELDS = 4,
    parameter int IDX_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  len_t             len,
    output logic [IDX_W-1:0] state_q,
    output len_t             cnt_q,
    output logic             last_bit,
    output logic             last_state
);
    assign last_state = (state_q == IDX_W'(NUM_FIELDS-1));
    assign last_bit   = start && (cnt_q == len - len_t'(1));

    always_ff @(posedge clk) begin
        if (rst || !start) begin
            state_q <= '0;
            cnt_q   <= '0;
        end else if (last_bit) begin
            cnt_q   <= '0;
            state_q <= last_state ? '0 : state_q + IDX_W'(1);
        end else begin
            cnt_q <= cnt_q + len_t'(1);
        end
    end

    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q < len);
    assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
        !start |=> (state_q == '0 && cnt_q == '0));
    assert_state_bound_R4: assert property (@(posedge clk) disable iff (rst)
        state_q <= IDX_W'(NUM_FIELDS-1));
endmodule

// File: rtl/sfd_shift.sv
module sfd_shift
    import sfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       sdata,
    input  len_t       cnt,
    input  logic       last_bit,
    output field_val_t val_q
);
    word_t acc_msb, acc_lsb;
    word_t nxt_msb, nxt_lsb;

    always_comb begin
        nxt_msb = {acc_msb[DATA_W-2:0], sdata};
        nxt_lsb = acc_lsb | (word_t'(sdata) << cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_msb <= '0;
            acc_lsb <= '0;
            val_q   <= '0;
        end else if (!start) begin
            acc_msb <= '0;
            acc_lsb <= '0;
        end else if (last_bit) begin
            val_q.msb <= nxt_msb;
            val_q.lsb <= nxt_lsb;
            acc_msb   <= '0;
            acc_lsb   <= '0;
        end else begin
            acc_msb <= nxt_msb;
            acc_lsb <= nxt_lsb;
        end
    end

    assert_discard_R2: assert property (@(posedge clk) disable iff (rst)
        !start |=> (acc_msb == '0 && acc_lsb == '0));
endmodule

// File: rtl/field_splitter.sv
module field_splitter
    import sfd_pkg::*;
#(
    parameter int NUM_FIELDS = 4,
    parameter logic [NUM_FIELDS*LEN_W-1:0] LEN_TABLE = {7'd8, 7'd0, 7'd64, 7'd1},
    localparam int IDX_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sdata,
    output logic             field_valid,
    output logic             frame_done,
    output logic [IDX_W-1:0] field_idx,
    output logic [63:0]      field_msb,
    output logic [63:0]      field_lsb
);
    logic [IDX_W-1:0] state_q;
    len_t             cnt_q, len;
    logic             last_bit, last_state;
    field_val_t       val_q;

    sfd_len_rom #(.NUM_FIELDS(NUM_FIELDS), .IDX_W(IDX_W), .LEN_TABLE(LEN_TABLE)) u_rom (
        .idx(state_q), .len(len)
    );

    sfd_seq #(.NUM_FIELDS(NUM_FIELDS), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .len(len),
        .state_q(state_q), .cnt_q(cnt_q), .last_bit(last_bit), .last_state(last_state)
    );

    sfd_shift u_shift (
        .clk(clk), .rst(rst), .start(start), .sdata(sdata),
        .cnt(cnt_q), .last_bit(last_bit), .val_q(val_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            field_valid <= 1'b0;
            frame_done  <= 1'b0;
            field_idx   <= '0;
        end else begin
            field_valid <= last_bit;
            frame_done  <= last_bit && last_state;
            if (last_bit) field_idx <= state_q;
        end
    end

    assign field_msb = val_q.msb;
    assign field_lsb = val_q.lsb;

    function automatic len_t tbl_len(input logic [IDX_W-1:0] i);
        len_t r = len_t'(1);
        for (int k = 0; k < NUM_FIELDS; k++)
            if (i == IDX_W'(k)) r = eff_len(LEN_TABLE[k*LEN_W +: LEN_W]);
        return r;
    endfunction

    assert_done_last_R8: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (field_valid && field_idx == IDX_W'(NUM_FIELDS-1)));
    assert_no_valid_after_drop_R2: assert property (@(posedge clk) disable iff (rst)
        !start |=> !field_valid);
    assert_reverse_pop_R6: assert property (@(posedge clk) disable iff (rst)
        field_valid |-> ($countones(field_msb) == $countones(field_lsb)));
    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        field_valid |-> (((field_msb | field_lsb) >> tbl_len(field_idx)) == '0));
endmodule

// File: tb/tb_field_splitter.sv
module tb_field_splitter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic sdata = 1'b0;

    logic        v_a, d_a, v_b, d_b;
    logic [1:0]  idx_a;
    logic [2:0]  idx_b;
    logic [63:0] msb_a, lsb_a, msb_b, lsb_b;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    field_splitter dut (
        .clk(clk), .rst(rst), .start(start), .sdata(sdata),
        .field_valid(v_a), .frame_done(d_a), .field_idx(idx_a),
        .field_msb(msb_a), .field_lsb(lsb_a)
    );

    field_splitter #(.NUM_FIELDS(7), .LEN_TABLE({7{7'd8}})) dut_b (
        .clk(clk), .rst(rst), .start(start), .sdata(sdata),
        .field_valid(v_b), .frame_done(d_b), .field_idx(idx_b),
        .field_msb(msb_b), .field_lsb(lsb_b)
    );

    // Reference tables written from the requirements
    int nf  [2] = '{4, 7};
    int raw [2][8] = '{'{1, 64, 0, 8, 0, 0, 0, 0}, '{8, 8, 8, 8, 8, 8, 8, 0}};
    int rst_st [2], rcnt [2];
    logic [63:0] rm [2], rl [2];

    function automatic int blen(int i, int s);
        return (raw[i][s] == 0) ? 1 : raw[i][s];
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            rst_st[i] = 0; rcnt[i] = 0; rm[i] = '0; rl[i] = '0;
        end
    endtask

    task automatic step(input logic st, input logic b);
        bit          ev, ed;
        int          eidx, l, r;
        logic [63:0] em, el;
        @(negedge clk);
        start = st;
        sdata = b;
        @(posedge clk);
        #1;
        for (int i = 0; i < 2; i++) begin
            ev = 0; ed = 0; eidx = 0; em = '0; el = '0; l = 1; r = 0;
            if (!st) begin
                rst_st[i] = 0; rcnt[i] = 0; rm[i] = '0; rl[i] = '0;
            end else begin
                l = blen(i, rst_st[i]);
                r = raw[i][rst_st[i]];
                rm[i] = (rm[i] << 1) | 64'(b);
                rl[i] = rl[i] | (64'(b) << rcnt[i]);
                if (rcnt[i] == l - 1) begin
                    ev = 1; eidx = rst_st[i]; em = rm[i]; el = rl[i];
                    ed = (rst_st[i] == nf[i] - 1);
                    rst_st[i] = ed ? 0 : rst_st[i] + 1;
                    rcnt[i] = 0; rm[i] = '0; rl[i] = '0;
                end else begin
                    rcnt[i]++;
                end
            end
            if (i == 0) begin
                chk(!st ? "R2" : (r == 0 ? "R9" : "R3"), 64'(v_a), 64'(ev));
                chk("R8", 64'(d_a), 64'(ed));
                if (ev) begin
                    chk("R4", 64'(idx_a), 64'(eidx));
                    chk(l == 64 ? "R10" : "R5", msb_a, em);
                    chk("R6", lsb_a, el);
                    if (l < 64) chk("R7", (msb_a | lsb_a) >> l, '0);
                end
            end else begin
                chk("R11", 64'(v_b), 64'(ev));
                chk("R11", 64'(d_b), 64'(ed));
                if (ev) begin
                    chk("R11", 64'(idx_b), 64'(eidx));
                    chk("R11", msb_b, em);
                    chk("R11", lsb_b, el);
                end
            end
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 12000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", 64'(v_a), 0);
        chk("R1", 64'(d_a), 0);
        chk("R1", msb_a, 0);
        chk("R1", lsb_a, 0);
        chk("R1", 64'(idx_a), 0);
        @(negedge clk);
        rst = 1'b0;

        // Directed: full frame, 64-bit all ones (R10), then a single bit
        step(1, 1);
        for (int k = 0; k < 64; k++) step(1, 1);
        step(1, 1);
        for (int k = 0; k < 8; k++) step(1, k[0]);
        // Wrap straight into the next frame (R8), then drop mid 64-bit field (R2)
        step(1, 0);
        for (int k = 0; k < 20; k++) step(1, 1);
        step(0, 1);
        step(0, 0);
        // Directed: alternating pattern across a whole frame
        for (int k = 0; k < 74; k++) step(1, k[1]);
        step(0, 0);

        // Random frames with random drops of start
        for (int n = 0; n < 2500; n++) begin
            logic st;
            st = ($urandom_range(0, 99) < 95);
            step(st, 1'($urandom_range(0, 1)));
        end
        step(0, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule